// File: doc/BRIEF.md
# Three-Phase Hall Commutation Decoder

This block turns the three digital Hall sensor levels of a brushless motor into enables for the three half-bridges. Each bridge has a high-side (source) switch and a low-side (sink) switch. For every legal rotor position, one phase sources current and a different phase sinks it, following a fixed six-step table. A direction input picks forward or reverse rotation. In reverse, the block reads the table through the bitwise complement of the Hall code, so each source/sink pair is reached from the inverted sensor pattern.

A drive-off input stands for any condition in which the bridge must not conduct, such as a stop request or a zero duty cycle. While drive-off is high, every enable is low. The active direction can only change on a cycle in which drive-off is high. A direction request made while the motor is being driven therefore waits for the next drive-off period, so a direction change can never leave one phase with both switches on. Speed chopping is applied outside the block, by gating the low-side enables.

The enables are registered. They reflect the Hall code, the drive-off level and the active direction as sampled at the previous rising clock edge.

Top module: `hall_commutator`

## Requirements
- R1: With forward direction active (0) and drive on, the Hall code `hall_lvl` = {sensor3, sensor2, sensor1} gives the following pairs, where enable bit 0/1/2 drives phase 1/2/3:
  - 3'b101: phase 2 sources, phase 1 sinks.
  - 3'b001: phase 3 sources, phase 1 sinks.
  - 3'b011: phase 3 sources, phase 2 sinks.
  - 3'b010: phase 1 sources, phase 2 sinks.
  - 3'b110: phase 1 sources, phase 3 sinks.
  - 3'b100: phase 2 sources, phase 3 sinks.
- R2: With reverse direction active (1) and drive on, a Hall code gives the pair that forward direction assigns to its bitwise complement. For example, 3'b010 gives phase 2 sourcing and phase 1 sinking.
- R3: Hall codes 3'b000 and 3'b111 drive all six enables low in either direction.
- R4: When `drive_off` is sampled high, all six enables are low after that clock edge.
- R5: The active direction takes the value of `dir_req` (0 = forward, 1 = reverse) only at clock edges where `drive_off` is high. A `dir_req` value present only while drive is on has no effect on the enables. A request held until the next drive-off period takes effect when drive resumes.
- R6: No phase ever has its high-side and low-side enables asserted together, and at most one enable of each side is high at any time.
- R7: While `rst` is high, all enables are low. After reset the active direction is reverse.
- R8: The enables change one clock edge after the inputs that select them, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| hall_lvl | input | 3 | Hall levels: bit0 sensor 1, bit1 sensor 2, bit2 sensor 3 |
| dir_req | input | 1 | Requested direction: 0 forward, 1 reverse |
| drive_off | input | 1 | High forces all enables off and allows a direction change |
| hi_en | output | 3 | High-side (source) enables, bit i for phase i+1 |
| lo_en | output | 3 | Low-side (sink) enables, bit i for phase i+1 |

## Verification
Capturing a new direction and forcing the bridge off happen on the same clock edge, and the first edge after drive-off drops also applies the newly captured direction to a fresh Hall code. The bench provokes this by changing `dir_req` and `hall_lvl` in the same cycle that `drive_off` rises. It then lowers `drive_off` and checks two things: the enables were all low for the off cycle, and the next pattern follows the new direction. In the opposite case, `dir_req` is flipped while drive is on and then restored before any drive-off cycle. The enables must keep following the old direction throughout.

// File: rtl/hall_comm_pkg.sv
package hall_comm_pkg;

    localparam int PHASES   = 3;
    localparam int HALL_W   = 3;
    localparam int PH_IDX_W = $clog2(PHASES);

    typedef logic [PHASES-1:0] phase_vec_t;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } dir_e;

    typedef struct packed {
        logic                valid;
        logic [PH_IDX_W-1:0] src;
        logic [PH_IDX_W-1:0] snk;
    } commute_t;

    typedef struct packed {
        phase_vec_t hi;
        phase_vec_t lo;
    } bridge_en_t;

    localparam bridge_en_t BRIDGE_OFF = '{hi: '0, lo: '0};

    // Six-step table indexed by the forward-normalised Hall code.
    function automatic commute_t step_lookup(input logic [HALL_W-1:0] code);
        commute_t r;
        r = '{valid: 1'b0, src: '0, snk: '0};
        case (code)
            3'b101: r = '{valid: 1'b1, src: PH_IDX_W'(1), snk: PH_IDX_W'(0)};
            3'b001: r = '{valid: 1'b1, src: PH_IDX_W'(2), snk: PH_IDX_W'(0)};
            3'b011: r = '{valid: 1'b1, src: PH_IDX_W'(2), snk: PH_IDX_W'(1)};
            3'b010: r = '{valid: 1'b1, src: PH_IDX_W'(0), snk: PH_IDX_W'(1)};
            3'b110: r = '{valid: 1'b1, src: PH_IDX_W'(0), snk: PH_IDX_W'(2)};
            3'b100: r = '{valid: 1'b1, src: PH_IDX_W'(1), snk: PH_IDX_W'(2)};
            default: r = '{valid: 1'b0, src: '0, snk: '0};
        endcase
        return r;
    endfunction

    // Reverse rotation reads the table through the inverted sensor pattern.
    function automatic logic [HALL_W-1:0] normalise(input logic [HALL_W-1:0] code,
                                                    input dir_e dir);
        return (dir == DIR_REV) ? ~code : code;
    endfunction

endpackage

// File: rtl/hall_step_decode.sv
module hall_step_decode
    import hall_comm_pkg::*;
(
    input  logic [HALL_W-1:0] hall_code,
    input  dir_e              dir,
    output commute_t          step
);
    logic [HALL_W-1:0] fwd_code;

    always_comb begin
        fwd_code = normalise(hall_code, dir);
        step     = step_lookup(fwd_code);
    end
endmodule

// File: rtl/dir_hold.sv
module dir_hold
    import hall_comm_pkg::*;
#(
    parameter dir_e RESET_DIR = DIR_REV
) (
    input  logic clk,
    input  logic rst,
    input  logic dir_req,
    input  logic take_en,
    output dir_e dir_act
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_act <= RESET_DIR;
        end else if (take_en) begin
            dir_act <= dir_e'(dir_req);
        end
    end
endmodule

// File: rtl/enable_drive.sv
module enable_drive
    import hall_comm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  commute_t   step,
    input  logic       kill,
    output bridge_en_t en_q
);
    bridge_en_t en_d;

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_phase
            always_comb begin
                en_d.hi[p] = step.valid && !kill && (step.src == PH_IDX_W'(p));
                en_d.lo[p] = step.valid && !kill && (step.snk == PH_IDX_W'(p));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= BRIDGE_OFF;
        end else begin
            en_q <= en_d;
        end
    end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hall_comm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALL_W-1:0] hall_lvl,
    input  logic              dir_req,
    input  logic              drive_off,
    output logic [PHASES-1:0] hi_en,
    output logic [PHASES-1:0] lo_en
);
    dir_e       dir_act;
    commute_t   step;
    bridge_en_t en_q;

    dir_hold #(.RESET_DIR(DIR_REV)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .dir_req (dir_req),
        .take_en (drive_off),
        .dir_act (dir_act)
    );

    hall_step_decode u_dec (
        .hall_code (hall_lvl),
        .dir       (dir_act),
        .step      (step)
    );

    enable_drive u_drv (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .kill (drive_off),
        .en_q (en_q)
    );

    assign hi_en = en_q.hi;
    assign lo_en = en_q.lo;
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk
    import hall_comm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [HALL_W-1:0] hall_lvl,
    input logic              dir_req,
    input logic              drive_off,
    input logic [PHASES-1:0] hi_en,
    input logic [PHASES-1:0] lo_en,
    input logic              dir_act
);
    a_r6_no_shoot: assert property (@(posedge clk) disable iff (rst)
        (hi_en & lo_en) == '0);

    a_r6_one_per_side: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hi_en) && $onehot0(lo_en));

    a_r4_off_after_kill: assert property (@(posedge clk) disable iff (rst)
        drive_off |=> (hi_en == '0 && lo_en == '0));

    a_r3_illegal_off: assert property (@(posedge clk) disable iff (rst)
        (hall_lvl == '0 || hall_lvl == '1) |=> (hi_en == '0 && lo_en == '0));

    a_r1_legal_pair: assert property (@(posedge clk) disable iff (rst)
        (!drive_off && hall_lvl != '0 && hall_lvl != '1)
        |=> ($countones(hi_en) == 1 && $countones(lo_en) == 1));

    a_r5_dir_frozen: assert property (@(posedge clk) disable iff (rst)
        !drive_off |=> $stable(dir_act));

    a_r5_dir_taken: assert property (@(posedge clk) disable iff (rst)
        drive_off |=> (dir_act == $past(dir_req)));
endmodule

bind hall_commutator hall_commutator_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hall_lvl  (hall_lvl),
    .dir_req   (dir_req),
    .drive_off (drive_off),
    .hi_en     (hi_en),
    .lo_en     (lo_en),
    .dir_act   (dir_act)
);

// File: tb/hall_commutator_test.sv
module hall_commutator_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 16;
    localparam int  WATCHDOG   = 20000;

    // {dir, hall[2:0], hi[2:0], lo[2:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 3'b101, 3'b010, 3'b001},
        {1'b0, 3'b001, 3'b100, 3'b001},
        {1'b0, 3'b011, 3'b100, 3'b010},
        {1'b0, 3'b010, 3'b001, 3'b010},
        {1'b0, 3'b110, 3'b001, 3'b100},
        {1'b0, 3'b100, 3'b010, 3'b100},
        {1'b1, 3'b010, 3'b010, 3'b001},
        {1'b1, 3'b110, 3'b100, 3'b001},
        {1'b1, 3'b100, 3'b100, 3'b010},
        {1'b1, 3'b101, 3'b001, 3'b010},
        {1'b1, 3'b001, 3'b001, 3'b100},
        {1'b1, 3'b011, 3'b010, 3'b100},
        {1'b0, 3'b000, 3'b000, 3'b000},
        {1'b0, 3'b111, 3'b000, 3'b000},
        {1'b1, 3'b000, 3'b000, 3'b000},
        {1'b1, 3'b111, 3'b000, 3'b000}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_lvl = 3'b101;
    logic       dir_req = 1'b0;
    logic       drive_off = 1'b0;
    logic [2:0] hi_en, lo_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hall_commutator uut (
        .clk       (clk),
        .rst       (rst),
        .hall_lvl  (hall_lvl),
        .dir_req   (dir_req),
        .drive_off (drive_off),
        .hi_en     (hi_en),
        .lo_en     (lo_en)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [2:0] ehi, input logic [2:0] elo);
        checks++;
        if (hi_en !== ehi || lo_en !== elo) begin
            fails++;
            $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, hi_en, lo_en, ehi, elo);
        end
        checks++;
        if ((hi_en & lo_en) !== 3'b000) begin
            fails++;
            $display("FAIL R6 overlap: hi=%b lo=%b expected no shared phase", hi_en, lo_en);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        check("R7 reset holds enables low", 3'b000, 3'b000);
        step();
        rst = 1'b0;
        // dir_req=0 but drive on: active direction still reverse after reset
        step();
        check("R7 reset direction reverse / R5 pending", 3'b001, 3'b010);

        // Vector table walk: each entry preceded by a drive-off cycle
        for (int i = 0; i < NVEC; i++) begin
            drive_off = 1'b1;
            dir_req   = VEC[i][9];
            step();
            check("R4 off cycle", 3'b000, 3'b000);
            drive_off = 1'b0;
            hall_lvl  = VEC[i][8:6];
            step();
            if (i < 6)       check("R1 forward table", VEC[i][5:3], VEC[i][2:0]);
            else if (i < 12) check("R2 reverse table", VEC[i][5:3], VEC[i][2:0]);
            else             check("R3 illegal code", VEC[i][5:3], VEC[i][2:0]);
        end

        // R8: single-edge latency while driving forward
        drive_off = 1'b1; dir_req = 1'b0; step();
        drive_off = 1'b0; hall_lvl = 3'b011; step();
        check("R8 first pattern", 3'b100, 3'b010);
        hall_lvl = 3'b010;
        @(posedge clk); #1;
        check("R8 one edge later", 3'b001, 3'b010);
        @(negedge clk);

        // R5: request while driving is ignored, then withdrawn
        dir_req = 1'b1; hall_lvl = 3'b110; step();
        check("R5 request ignored while driving", 3'b001, 3'b100);
        step();
        check("R5 still forward", 3'b001, 3'b100);
        dir_req = 1'b0; drive_off = 1'b1; step();
        drive_off = 1'b0; step();
        check("R5 withdrawn request has no effect", 3'b001, 3'b100);

        // Same-edge collision: drive-off rises with new direction and new code
        dir_req = 1'b1; hall_lvl = 3'b001; drive_off = 1'b1; step();
        check("R4 collision off cycle", 3'b000, 3'b000);
        drive_off = 1'b0; step();
        check("R5 collision new direction applied", 3'b001, 3'b100);

        // R4: drive-off mid-run clears enables, release restores pattern
        drive_off = 1'b1; step();
        check("R4 mid-run off", 3'b000, 3'b000);
        drive_off = 1'b0; step();
        check("R4 release", 3'b001, 3'b100);

        // R7: reset while driving clears enables
        rst = 1'b1; step();
        check("R7 reset mid-run", 3'b000, 3'b000);
        rst = 1'b0; dir_req = 1'b0; hall_lvl = 3'b101; step();
        check("R7 reverse after second reset", 3'b001, 3'b010);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule